// File: doc/BRIEF.md
# Dual-Channel Overload Level Detector

This block watches the in-phase and quadrature sample streams that leave a pair of oversampled converters. It warns when either stream carries more signal than the modulator can take. Each channel has its own detector. The detector rectifies every valid sample and smooths the magnitude with a first-order leaky integrator whose decay is a right shift. The smoothed level of each channel is compared against one shared 16-bit threshold, and the two results are ORed into a single registered overload flag.

The flag follows the live level and does not latch. A processor polls it, lowers the gain one step at a time, and stops when the flag falls back low on its own. Software loads the threshold through a write-enable/data pair. A new value is used from the next valid sample onward.

Top module: `ovl_level_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, both integrators clear to zero, the threshold register loads its reset value (default 16'hFFFF), and `ovl_flag` is low after that edge.
- R2: A channel's detector input is the magnitude of its two's-complement sample, so a sample of -X and a sample of +X move the integrator by the same amount.
- R3: On each clock edge with `in_valid` high, each integrator updates as acc_new = acc - (acc >> DECAY_SH) + |sample|. The channel level is acc_new >> DECAY_SH, zero-extended to 16 bits. DECAY_SH is 3 by default.
- R4: The comparison is strictly greater-than: a level equal to the threshold does not raise the flag.
- R5: On a valid edge, `ovl_flag` becomes 1 if the I level or the Q level (or both) exceeds the threshold, and 0 otherwise. The flag appears one clock after the valid sample.
- R6: The flag does not stick: it returns low at the first valid sample at which both levels are at or below the threshold, with no read or clear action needed.
- R7: On edges with `in_valid` low, `ovl_flag` and both integrators hold their values.
- R8: A write (`thr_we` high) stores `thr_wdata`. The stored value is first used by the next valid sample after the write cycle. A valid sample in the same cycle as the write still compares against the old threshold, and a write alone never changes the flag.
- R9: The most negative sample, -2^(SAMPLE_W-1), is treated as magnitude 2^(SAMPLE_W-1) with no overflow. A constant full-scale input settles at a level of exactly 2^(SAMPLE_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_i` and `in_q` in this cycle |
| in_i | input | SAMPLE_W | In-phase sample, two's complement |
| in_q | input | SAMPLE_W | Quadrature sample, two's complement |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | THR_W | Threshold value to store, unsigned |
| ovl_flag | output | 1 | Registered overload flag, live level |

## Verification
The assertions assume that `rst` is held high from time zero through at least one clock edge. They also assume that `in_valid`, the samples and the threshold port change only away from the rising edge, so every property can sample a settled view of each valid cycle. The bench drives all inputs on the falling edge. It holds `in_valid` for exactly one cycle per sample and spaces some samples with idle cycles, so the hold property and the post-valid comparison property are both exercised. Threshold writes are issued alone, together with a valid sample, and between samples. This covers the cases the threshold-timing property relies on.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int NCH  = 2;
  localparam int CH_I = 0;
  localparam int CH_Q = 1;
endpackage

// File: rtl/ovl_magnitude.sv
module ovl_magnitude #(
  parameter int SAMPLE_W = 14
) (
  input  logic signed [SAMPLE_W-1:0] smp,
  output logic        [SAMPLE_W-1:0] mag
);
  logic signed [SAMPLE_W:0] ext;
  logic signed [SAMPLE_W:0] neg;

  always_comb begin
    ext = {smp[SAMPLE_W-1], smp};
    neg = -ext;
    mag = ext[SAMPLE_W] ? neg[SAMPLE_W-1:0] : ext[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/ovl_leaky_integ.sv
module ovl_leaky_integ #(
  parameter int SAMPLE_W = 14,
  parameter int DECAY_SH = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] mag,
  output logic [SAMPLE_W-1:0] lvl_next,
  output logic [SAMPLE_W-1:0] lvl
);
  localparam int ACC_W = SAMPLE_W + DECAY_SH;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d    = acc_q - (acc_q >> DECAY_SH) + ACC_W'(mag);
    lvl_next = acc_d[ACC_W-1:DECAY_SH];
    lvl      = acc_q[ACC_W-1:DECAY_SH];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/ovl_detector.sv
module ovl_detector #(
  parameter int SAMPLE_W = 14,
  parameter int DECAY_SH = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp,
  output logic        [SAMPLE_W-1:0] lvl_next,
  output logic        [SAMPLE_W-1:0] lvl
);
  logic [SAMPLE_W-1:0] mag;

  ovl_magnitude #(.SAMPLE_W(SAMPLE_W)) u_mag (
    .smp (smp),
    .mag (mag)
  );

  ovl_leaky_integ #(.SAMPLE_W(SAMPLE_W), .DECAY_SH(DECAY_SH)) u_integ (
    .clk      (clk),
    .rst      (rst),
    .en       (smp_valid),
    .mag      (mag),
    .lvl_next (lvl_next),
    .lvl      (lvl)
  );
endmodule

// File: rtl/ovl_level_monitor.sv
module ovl_level_monitor #(
  parameter int              SAMPLE_W  = 14,
  parameter int              DECAY_SH  = 3,
  parameter int              THR_W     = 16,
  parameter logic [THR_W-1:0] THR_RESET = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic                thr_we,
  input  logic [THR_W-1:0]    thr_wdata,
  output logic                ovl_flag
);
  import ovl_pkg::*;

  logic signed [SAMPLE_W-1:0] smp_arr  [NCH];
  logic        [SAMPLE_W-1:0] lvl_nx   [NCH];
  logic        [SAMPLE_W-1:0] lvl_reg  [NCH];
  logic        [NCH-1:0]      over_ch;
  logic        [THR_W-1:0]    thr_q;

  assign smp_arr[CH_I] = in_i;
  assign smp_arr[CH_Q] = in_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ovl_detector #(.SAMPLE_W(SAMPLE_W), .DECAY_SH(DECAY_SH)) u_det (
      .clk       (clk),
      .rst       (rst),
      .smp_valid (in_valid),
      .smp       (smp_arr[c]),
      .lvl_next  (lvl_nx[c]),
      .lvl       (lvl_reg[c])
    );
    assign over_ch[c] = THR_W'(lvl_nx[c]) > thr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= THR_RESET;
    end else if (thr_we) begin
      thr_q <= thr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_flag <= 1'b0;
    end else if (in_valid) begin
      ovl_flag <= |over_ch;
    end
  end
endmodule

// File: rtl/ovl_level_monitor_chk.sv
module ovl_level_monitor_chk #(
  parameter int SAMPLE_W = 14,
  parameter int THR_W    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [THR_W-1:0]    thr_q,
  input logic [SAMPLE_W-1:0] lvl_i,
  input logic [SAMPLE_W-1:0] lvl_q,
  input logic                ovl_flag
);
  localparam logic [SAMPLE_W:0] FULL = (SAMPLE_W+1)'(1) << (SAMPLE_W-1);

  // R1: reset forces the flag low
  a_r1_reset_flag_low: assert property (@(posedge clk) rst |=> !ovl_flag);

  // R7: no valid sample, no change of the flag
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ovl_flag));

  // R5: after a valid sample the flag matches the updated levels against the threshold in use
  a_r5_flag_matches_levels: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ovl_flag == ((THR_W'(lvl_i) > $past(thr_q)) || (THR_W'(lvl_q) > $past(thr_q))));

  // R9: levels never exceed full-scale magnitude
  a_r9_level_bounded: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, lvl_i} <= FULL) && ({1'b0, lvl_q} <= FULL));
endmodule

bind ovl_level_monitor ovl_level_monitor_chk #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .thr_q    (thr_q),
  .lvl_i    (lvl_reg[0]),
  .lvl_q    (lvl_reg[1]),
  .ovl_flag (ovl_flag)
);

// File: tb/tb_ovl_level_monitor.sv
module tb_ovl_level_monitor;
  localparam int SW = 14;
  localparam int SH = 3;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_i = '0;
  logic [SW-1:0] in_q = '0;
  logic          thr_we = 1'b0;
  logic [TW-1:0] thr_wdata = '0;
  logic          ovl_flag;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  // model state
  int m_acc_i = 0;
  int m_acc_q = 0;
  int m_thr = 65535;
  bit m_flag = 0;

  bit    exp_q[$];
  string tag_q[$];

  ovl_level_monitor dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .ovl_flag(ovl_flag)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ovl_flag=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mag_of(input int s);
    return (s < 0) ? -s : s;
  endfunction

  // driver: one valid sample, optional threshold write in the same cycle
  task automatic send(input int si, input int sq, input bit we, input int wd, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_i      = SW'(si);
    in_q      = SW'(sq);
    thr_we    = we;
    thr_wdata = TW'(wd);
    m_acc_i = m_acc_i - (m_acc_i >> SH) + mag_of(si);
    m_acc_q = m_acc_q - (m_acc_q >> SH) + mag_of(sq);
    m_flag  = ((m_acc_i >> SH) > m_thr) || ((m_acc_q >> SH) > m_thr);
    if (we) m_thr = wd;
    exp_q.push_back(m_flag);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    thr_we   = 1'b0;
  endtask

  task automatic write_thr(input int wd);
    @(negedge clk);
    thr_we = 1'b1;
    thr_wdata = TW'(wd);
    m_thr = wd;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // monitor: compare the flag one edge after each valid sample
  initial begin
    forever begin
      @(posedge clk);
      if (in_valid && !rst) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check(ovl_flag, 1'b0, "R5 unexpected result");
        end else begin
          check(ovl_flag, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ovl_flag, 1'b0, "R1 flag low in reset");
    rst = 1'b0;
    @(negedge clk);
    check(ovl_flag, 1'b0, "R1 flag low after reset");
    // R1: reset threshold is all ones, so full scale cannot trip it
    for (int k = 0; k < 40; k++) send(8191, -8192, 0, 0, "R1 reset threshold");
    // re-reset and confirm integrators cleared (R1)
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_acc_i = 0; m_acc_q = 0; m_thr = 65535;
    check(ovl_flag, 1'b0, "R1 flag low after second reset");
    write_thr(0);
    send(0, 0, 0, 0, "R1 integrators cleared");
    send(8, 0, 0, 0, "R3 first step");

    // R3/R5: I channel alone ramps over threshold
    write_thr(500);
    for (int k = 0; k < 30; k++) send(1000, 0, 0, 0, "R5 I channel over");
    // R6: drop input, flag clears by itself
    for (int k = 0; k < 40; k++) send(0, 0, 0, 0, "R6 decay clears");
    // R2/R5: Q channel negative only
    for (int k = 0; k < 30; k++) send(0, -1000, 0, 0, "R2 negative Q over");
    for (int k = 0; k < 40; k++) send(0, 0, 0, 0, "R6 decay clears Q");
    // R2: mixed signs alternating
    for (int k = 0; k < 30; k++) send((k % 2) ? 700 : -700, (k % 2) ? -300 : 300, 0, 0, "R2 alternating sign");

    // R4: settle at level exactly 600, threshold equal -> low
    write_thr(600);
    for (int k = 0; k < 120; k++) send(600, -600, 0, 0, "R4 equal not over");
    write_thr(599);
    send(600, -600, 0, 0, "R4 one below over");

    // R8: write alone does not change the flag
    write_thr(2000);
    idle(2);
    check(ovl_flag, 1'b1, "R8 write alone holds flag");
    send(600, 600, 0, 0, "R8 new threshold applied");
    // R8: write with valid uses old threshold, then new one
    send(600, 600, 1, 100, "R8 same-cycle write uses old");
    send(600, 600, 0, 0, "R8 next sample uses new");

    // R7: idle cycles hold state
    idle(5);
    check(ovl_flag, 1'b1, "R7 idle hold");
    write_thr(5000);
    for (int k = 0; k < 3; k++) begin
      send(600, 600, 0, 0, "R7 sparse samples");
      idle(3);
    end

    // R9: most negative sample settles at full scale
    write_thr(8191);
    for (int k = 0; k < 150; k++) send(-8192, 0, 0, 0, "R9 full scale over");
    write_thr(8192);
    send(-8192, 0, 0, 0, "R9 full scale equal");

    idle(4);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R5 pending results: got %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule